// File: doc/BRIEF.md
# Even/Odd Sync Table Lock Controller

This block arbitrates access to two banks of clock-sync measurement tables, one filled in even communication cycles and one in odd cycles. A protocol engine rewrites a bank once per matching cycle. A host can freeze one bank or both so that it reads consistent data. For each parity the block tracks four things: a host lock, an update-in-progress state, a valid flag and the cycle number in which the bank was last recorded. The engine's table write enable for a parity is asserted only while an update the block has accepted is running, so a locked bank is never written.

The host toggles a lock by writing 1 to that parity's trigger bit. A lock requested while that bank is being rewritten takes effect only when the rewrite finishes. The block reports a single cycle number chosen by which banks are locked. It also holds the base offset of the tables, which is kept to an even value.

Top module: `sync_tbl_lock`

## Requirements
- R1: After reset, both locks are clear, both valid flags are 0, both write enables are 0, the reported cycle number is 0 and the base offset is 0.
- R2: A control write with trigger bit p = 1 (bit 0 even, bit 1 odd) toggles lock p, visible one cycle after the write, when that parity has no update running and no start in the same cycle. A control write with a trigger bit of 0 leaves that lock unchanged.
- R3: An update start on an unlocked, idle parity drops its valid flag and raises its write enable in the next cycle. The matching done strobe raises the valid flag, drops the write enable and records the engine's current cycle number, all in the next cycle.
- R4: An update start or done strobe on a locked parity is ignored. Its valid flag, write enable and recorded cycle stay unchanged.
- R5: A trigger that arrives while a parity's update is running does not change its lock. The lock is granted in the cycle after the done strobe, together with the rising valid flag. A second trigger before done withdraws the request.
- R6: When a trigger and an accepted start reach an idle, unlocked parity in the same cycle, the start wins and the lock is deferred as in R5.
- R7: The reported cycle number is the odd bank's recorded cycle when only the odd lock is held. In every other lock combination it is the even bank's recorded cycle.
- R8: A base offset write stores the written value with bit 0 forced to 0.
- R9: Both trigger bits in one control write act independently, each on its own parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_ctl_wr | input | 1 | Host control write strobe |
| host_trig | input | 2 | Lock toggle triggers, bit 0 even, bit 1 odd |
| host_base_wr | input | 1 | Host base offset write strobe |
| host_base_data | input | OFS_W | Base offset write data |
| lock_sts | output | 2 | Lock status per parity |
| tbl_valid | output | 2 | Table valid flag per parity |
| cycle_num | output | CYC_W | Recorded cycle of the selected bank |
| base_offset | output | OFS_W | Table base offset, bit 0 always 0 |
| eng_start | input | 2 | Engine update start strobe per parity |
| eng_done | input | 2 | Engine update done strobe per parity |
| eng_cycle | input | CYC_W | Engine's current cycle number |
| eng_wr_en | output | 2 | Table write enable per parity |

## Verification
A wrong lock or busy state in this block shows at the ports within one cycle. It appears either as a write enable that is raised while the parity's lock is held, or as a valid flag that drops on a start that should have been ignored. A deferred-lock bookkeeping error appears in the cycle after the done strobe, where lock and valid must rise together. A wrong selection or a wrong capture of the recorded cycle appears on the cycle number output as soon as the lock combination is changed. The bench therefore compares every output after every step.

// File: rtl/sync_tbl_lock.sv
module sync_tbl_lock #(
  parameter int OFS_W = 16,
  parameter int CYC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_ctl_wr,
  input  logic [1:0]       host_trig,
  input  logic             host_base_wr,
  input  logic [OFS_W-1:0] host_base_data,
  output logic [1:0]       lock_sts,
  output logic [1:0]       tbl_valid,
  output logic [CYC_W-1:0] cycle_num,
  output logic [OFS_W-1:0] base_offset,
  input  logic [1:0]       eng_start,
  input  logic [1:0]       eng_done,
  input  logic [CYC_W-1:0] eng_cycle,
  output logic [1:0]       eng_wr_en
);

  logic [1:0]       lock_q, busy_q, pend_q, valid_q;
  logic [CYC_W-1:0] rec_q [2];
  logic [1:0]       trig, acc_start, fin;

  assign trig      = host_trig & {2{host_ctl_wr}};
  assign acc_start = eng_start & ~lock_q & ~busy_q;
  assign fin       = eng_done & busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q  <= '0;
      busy_q  <= '0;
      pend_q  <= '0;
      valid_q <= '0;
      rec_q[0] <= '0;
      rec_q[1] <= '0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (acc_start[p]) begin
          busy_q[p]  <= 1'b1;
          valid_q[p] <= 1'b0;
        end
        if (fin[p]) begin
          busy_q[p]  <= 1'b0;
          valid_q[p] <= 1'b1;
          rec_q[p]   <= eng_cycle;
          lock_q[p]  <= pend_q[p] ^ trig[p];
          pend_q[p]  <= 1'b0;
        end else if (trig[p]) begin
          if (lock_q[p])                     lock_q[p] <= 1'b0;
          else if (busy_q[p] || acc_start[p]) pend_q[p] <= ~pend_q[p];
          else                               lock_q[p] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            base_offset <= '0;
    else if (host_base_wr) base_offset <= {host_base_data[OFS_W-1:1], 1'b0};
  end

  assign lock_sts  = lock_q;
  assign tbl_valid = valid_q;
  assign eng_wr_en = busy_q;
  assign cycle_num = (lock_q == 2'b10) ? rec_q[1] : rec_q[0];

  for (genvar g = 0; g < 2; g++) begin : g_chk
    p_lock_gates_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lock_sts[g] |-> !eng_wr_en[g]);
    p_locked_start_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_start[g] && lock_sts[g]) |=> ($stable(tbl_valid[g]) && !eng_wr_en[g]));
    p_done_sets_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done[g] && eng_wr_en[g]) |=> (tbl_valid[g] && !eng_wr_en[g]));
    p_lock_deferred_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_ctl_wr && host_trig[g] && eng_wr_en[g] && !eng_done[g]) |=> !lock_sts[g]);
    p_valid_low_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      eng_wr_en[g] |-> !tbl_valid[g]);
  end

  p_base_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_base_wr |=> !base_offset[0]);

endmodule

// File: tb/sync_tbl_lock_tb.sv
module sync_tbl_lock_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_ctl_wr = 1'b0, host_base_wr = 1'b0;
  logic [1:0] host_trig = '0, eng_start = '0, eng_done = '0;
  logic [15:0] host_base_data = '0;
  logic [5:0] eng_cycle = '0;
  logic [1:0] lock_sts, tbl_valid, eng_wr_en;
  logic [5:0] cycle_num;
  logic [15:0] base_offset;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_tbl_lock dut_i (
    .clk(clk), .rst_n(rst_n), .host_ctl_wr(host_ctl_wr), .host_trig(host_trig),
    .host_base_wr(host_base_wr), .host_base_data(host_base_data),
    .lock_sts(lock_sts), .tbl_valid(tbl_valid), .cycle_num(cycle_num),
    .base_offset(base_offset), .eng_start(eng_start), .eng_done(eng_done),
    .eng_cycle(eng_cycle), .eng_wr_en(eng_wr_en)
  );

  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [27:0] exp_q [$];
  string       tag_q [$];

  logic [1:0] x_lock = '0, x_val = '0, x_wr = '0;
  logic [5:0] rec_e = '0, rec_o = '0;
  logic [15:0] x_base = '0;

  function automatic logic [5:0] sel_cyc();
    return (x_lock == 2'b10) ? rec_o : rec_e;  // R7 rule
  endfunction

  task automatic push(string tag);
    exp_q.push_back({x_lock, x_val, x_wr, sel_cyc(), x_base});
    tag_q.push_back(tag);
  endtask

  task automatic step(input logic ctl, input logic [1:0] trg, input logic [1:0] st,
                      input logic [1:0] dn, input logic [5:0] cyc,
                      input logic bw, input logic [15:0] bd);
    @(negedge clk);
    host_ctl_wr = ctl; host_trig = trg; eng_start = st; eng_done = dn;
    eng_cycle = cyc; host_base_wr = bw; host_base_data = bd;
    @(posedge clk);
    #1;
    host_ctl_wr = 0; host_trig = 0; eng_start = 0; eng_done = 0; host_base_wr = 0;
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [27:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {lock_sts, tbl_valid, eng_wr_en, cycle_num, base_offset};
      n_vec++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: actual lock=%b val=%b wr=%b cyc=%0d base=%h expected lock=%b val=%b wr=%b cyc=%0d base=%h",
                 t, a[27:26], a[25:24], a[23:22], a[21:16], a[15:0],
                 e[27:26], e[25:24], e[23:22], e[21:16], e[15:0]);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    push("R1 reset state");
    step(0, 2'b00, 2'b00, 2'b00, 6'd0, 0, 16'h0);        push("R1 idle");
    step(0, 2'b00, 2'b00, 2'b00, 6'd0, 1, 16'hABCD);
    x_base = 16'hABCC;                                      push("R8 base lsb");
    step(0, 2'b00, 2'b01, 2'b00, 6'd4, 0, 16'h0);
    x_wr = 2'b01;                                           push("R3 even start");
    step(0, 2'b00, 2'b00, 2'b01, 6'd4, 0, 16'h0);
    x_wr = 2'b00; x_val = 2'b01; rec_e = 6'd4;              push("R3 even done");
    step(0, 2'b00, 2'b10, 2'b00, 6'd5, 0, 16'h0);
    x_wr = 2'b10;                                           push("R3 odd start");
    step(0, 2'b00, 2'b00, 2'b10, 6'd5, 0, 16'h0);
    x_wr = 2'b00; x_val = 2'b11; rec_o = 6'd5;              push("R3 odd done");
    step(1, 2'b00, 2'b00, 2'b00, 6'd5, 0, 16'h0);          push("R2 zero trigger");
    step(1, 2'b10, 2'b00, 2'b00, 6'd5, 0, 16'h0);
    x_lock = 2'b10;                                         push("R7 odd only locked");
    step(0, 2'b00, 2'b10, 2'b00, 6'd7, 0, 16'h0);          push("R4 locked start");
    step(0, 2'b00, 2'b00, 2'b10, 6'd7, 0, 16'h0);          push("R4 locked done");
    step(1, 2'b01, 2'b00, 2'b00, 6'd7, 0, 16'h0);
    x_lock = 2'b11;                                         push("R7 both locked");
    step(1, 2'b11, 2'b00, 2'b00, 6'd7, 0, 16'h0);
    x_lock = 2'b00;                                         push("R9 both unlock");
    step(0, 2'b00, 2'b01, 2'b00, 6'd8, 0, 16'h0);
    x_val = 2'b10; x_wr = 2'b01;                            push("R3 even start 2");
    step(1, 2'b01, 2'b00, 2'b00, 6'd8, 0, 16'h0);          push("R5 trig during update");
    step(0, 2'b00, 2'b00, 2'b01, 6'd9, 0, 16'h0);
    x_val = 2'b11; x_wr = 2'b00; x_lock = 2'b01; rec_e = 6'd9; push("R5 lock after done");
    step(1, 2'b01, 2'b00, 2'b00, 6'd9, 0, 16'h0);
    x_lock = 2'b00;                                         push("R2 even unlock");
    step(1, 2'b10, 2'b10, 2'b00, 6'd10, 0, 16'h0);
    x_val = 2'b01; x_wr = 2'b10;                            push("R6 start wins");
    step(1, 2'b10, 2'b00, 2'b00, 6'd10, 0, 16'h0);         push("R5 withdraw request");
    step(0, 2'b00, 2'b00, 2'b10, 6'd11, 0, 16'h0);
    x_val = 2'b11; x_wr = 2'b00; rec_o = 6'd11;             push("R5 withdrawn stays unlocked");
    step(1, 2'b10, 2'b10, 2'b00, 6'd12, 0, 16'h0);
    x_val = 2'b01; x_wr = 2'b10;                            push("R6 start wins 2");
    step(0, 2'b00, 2'b00, 2'b10, 6'd13, 0, 16'h0);
    x_val = 2'b11; x_wr = 2'b00; x_lock = 2'b10; rec_o = 6'd13; push("R7 odd lock reports odd");
    repeat (3) @(posedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule